// File: doc/BRIEF.md
# Dual-Ratio Alternating Clock Divider

This block derives a slow clock, for example about 32.768 kHz from a 24 MHz reference, from the reference itself. A single integer divider cannot reach such a target exactly. The block therefore alternates between two integer ratios. It spends a programmable number of output periods at the first ratio and then a programmable number at the second, so the long-run average ratio lies between the two.

The configuration arrives as two 32-bit words held steady by the surrounding logic. An input gate starts and freezes the divider. An output gate masks the divided clock without ever cutting a pulse short. A bypass hands the reference clock straight to the output. The normal reprogramming order is to close both gates, load the ratios and counts, open the input gate, and then open the output gate.

Top module: `altdiv_clkgen`

## Requirements
- R1: Word A holds ratio RA in bits [11:0], ratio RB in bits [23:12], the alternate enable at bit 28, the output gate at bit 30 and the input gate at bit 31. Word B holds repeat count CA in bits [11:0], repeat count CB in bits [23:12] and bypass at bit 24. Every ratio and count is stored as its value minus one.
- R2: With the alternate enable clear, every output period lasts RA reference cycles. It is high for floor(RA/2) cycles and low for the remainder, and RB, CA and CB have no effect.
- R3: With the alternate enable set, the output gives CA periods of ratio RA, then CB periods of ratio RB, and repeats this pattern indefinitely.
- R4: A ratio written during a period takes effect only from the next period boundary.
- R5: While the input gate is closed, the output is low and all counters are held cleared. The first period after the gate reopens always uses ratio RA.
- R6: A change of the output gate is applied only while the divided level is low. A closed output gate holds the output low, and no pulse is ever shortened.
- R7: With bypass set, the output equals the reference clock, whatever the gates and the division state.
- R8: A synchronous active-low reset drives the output low and selects the RA phase.
- R9: A ratio of one gives a permanently low output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cfg_a_i | input | 32 | Ratios, alternate enable and gates |
| cfg_b_i | input | 32 | Repeat counts and bypass |
| clk_o | output | 1 | Divided (or bypassed) clock |

## Verification
The output gate and the pulse generator can act in the same cycle. A gate request can arrive while a pulse is high, and the gate register and the divided level then both change on one edge. The bench provokes this by opening and closing the gate in the second cycle of a pulse. It then checks cycle by cycle that the pulse runs to its full length, or is suppressed entirely, and that the next period is whole. A ratio rewrite in mid-period and a gate closure during the second ratio phase are judged in the same way, against a pattern computed from the written fields.

// File: rtl/altdiv_pkg.sv
`timescale 1ns/1ps
// Package: field widths and bit positions of the two configuration words.
// Assumes both words are 32 bits and that the two fields of a word are adjacent.
package altdiv_pkg;
    localparam int FIELD_W   = 12;
    localparam int CFG_W     = 32;
    localparam int LO_LSB    = 0;
    localparam int HI_LSB    = LO_LSB + FIELD_W;
    localparam int ALT_BIT   = 28;
    localparam int OGATE_BIT = 30;
    localparam int IGATE_BIT = 31;
    localparam int BYP_BIT   = 24;
endpackage

// File: rtl/altdiv_period.sv
`timescale 1ns/1ps
// Period generator: counts reference cycles within one output period.
// The period length (ratio minus one) is latched at the period start, so a
// ratio written mid-period waits for the boundary. Level is high for the
// first floor(N/2) cycles. Held cleared while run_i is low.
module altdiv_period #(
    parameter int FW = altdiv_pkg::FIELD_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          phase_i,
    input  logic [FW-1:0] ratio_a_i,
    input  logic [FW-1:0] ratio_b_i,
    output logic          wrap_o,
    output logic          lvl_d_o,
    output logic          lvl_q_o,
    output logic [FW-1:0] cnt_o,
    output logic [FW-1:0] len_o
);
    logic [FW-1:0] cnt_q, len_q, len_eff, sel;
    logic [FW:0]   half;

    // Pick ratio of the active phase; take it only when a period starts
    assign sel     = phase_i ? ratio_b_i : ratio_a_i;
    assign len_eff = (cnt_q == '0) ? sel : len_q;
    assign half    = ({1'b0, len_eff} + 1'b1) >> 1;
    assign wrap_o  = run_i && (cnt_q == len_eff);
    assign lvl_d_o = run_i && ({1'b0, cnt_q} < half);

    // Advance the in-period counter and register the divided level
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            cnt_q   <= '0;
            len_q   <= '0;
            lvl_q_o <= 1'b0;
        end else begin
            len_q   <= len_eff;
            cnt_q   <= wrap_o ? '0 : cnt_q + 1'b1;
            lvl_q_o <= lvl_d_o;
        end
    end

    assign cnt_o = cnt_q;
    assign len_o = len_q;
endmodule

// File: rtl/altdiv_sequencer.sv
`timescale 1ns/1ps
// Phase sequencer: counts finished periods and flips between ratio A and B
// after the programmed repeat count of the active phase. Single mode pins the
// phase to A at each boundary. Cleared to phase A while run_i is low.
module altdiv_sequencer #(
    parameter int FW = altdiv_pkg::FIELD_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          alt_i,
    input  logic          wrap_i,
    input  logic [FW-1:0] rep_a_i,
    input  logic [FW-1:0] rep_b_i,
    output logic          phase_o
);
    logic [FW-1:0] rep_q;
    logic [FW-1:0] rep_lim;

    assign rep_lim = phase_o ? rep_b_i : rep_a_i;

    // Count periods and switch phase at a period boundary
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            rep_q   <= '0;
            phase_o <= 1'b0;
        end else if (wrap_i) begin
            if (!alt_i) begin
                rep_q   <= '0;
                phase_o <= 1'b0;
            end else if (rep_q == rep_lim) begin
                rep_q   <= '0;
                phase_o <= ~phase_o;
            end else begin
                rep_q   <= rep_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/altdiv_outstage.sv
`timescale 1ns/1ps
// Output stage: the output-gate register follows its request only while the
// divided level is low; the output is one register fed by level and gate.
// Bypass selects the reference clock combinationally.
module altdiv_outstage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_d_i,
    input  logic lvl_q_i,
    input  logic gate_req_i,
    input  logic bypass_i,
    output logic gate_q_o,
    output logic out_q_o,
    output logic clk_o
);
    logic gate_d;

    assign gate_d = lvl_q_i ? gate_q_o : gate_req_i;

    // Register gate state and the gated output level
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gate_q_o <= 1'b0;
            out_q_o  <= 1'b0;
        end else begin
            gate_q_o <= gate_d;
            out_q_o  <= lvl_d_i & gate_d;
        end
    end

    assign clk_o = bypass_i ? clk_i : out_q_o;
endmodule

// File: rtl/altdiv_clkgen.sv
`timescale 1ns/1ps
// Top: dual-ratio alternating clock divider. Decodes the two configuration
// words and wires the period generator, phase sequencer and output stage.
// Assumes the configuration is static apart from deliberate rewrites.
module altdiv_clkgen
    import altdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_a_i,
    input  logic [CFG_W-1:0] cfg_b_i,
    output logic             clk_o
);
    logic [FIELD_W-1:0] ratio_a, ratio_b, rep_a, rep_b, cnt, len;
    logic alt_en, in_gate, gate_req, bypass_en;
    logic phase, wrap, lvl_d, lvl_q, gate_q, out_q;
    logic unused_cfg;

    assign ratio_a   = cfg_a_i[LO_LSB +: FIELD_W];
    assign ratio_b   = cfg_a_i[HI_LSB +: FIELD_W];
    assign rep_a     = cfg_b_i[LO_LSB +: FIELD_W];
    assign rep_b     = cfg_b_i[HI_LSB +: FIELD_W];
    assign alt_en    = cfg_a_i[ALT_BIT];
    assign gate_req  = cfg_a_i[OGATE_BIT];
    assign in_gate   = cfg_a_i[IGATE_BIT];
    assign bypass_en = cfg_b_i[BYP_BIT];
    assign unused_cfg = ^{cfg_a_i[27:24], cfg_a_i[29], cfg_b_i[31:25]};

    altdiv_period #(.FW(FIELD_W)) u_period (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_gate), .phase_i(phase),
        .ratio_a_i(ratio_a), .ratio_b_i(ratio_b), .wrap_o(wrap),
        .lvl_d_o(lvl_d), .lvl_q_o(lvl_q), .cnt_o(cnt), .len_o(len)
    );

    altdiv_sequencer #(.FW(FIELD_W)) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_gate), .alt_i(alt_en),
        .wrap_i(wrap), .rep_a_i(rep_a), .rep_b_i(rep_b), .phase_o(phase)
    );

    altdiv_outstage u_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_d_i(lvl_d), .lvl_q_i(lvl_q),
        .gate_req_i(gate_req), .bypass_i(bypass_en), .gate_q_o(gate_q),
        .out_q_o(out_q), .clk_o(clk_o)
    );
endmodule

// File: rtl/altdiv_clkgen_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the divider, bound into the top module.
module altdiv_clkgen_chk #(
    parameter int FW = altdiv_pkg::FIELD_W
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          in_gate,
    input logic          alt_en,
    input logic          phase,
    input logic          lvl_q,
    input logic          gate_q,
    input logic          out_q,
    input logic [FW-1:0] cnt,
    input logic [FW-1:0] len
);
    AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt != '0) |-> (cnt <= len)); // R2
    AST_PHASE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_gate && cnt != '0 && cnt != len) |=> $stable(phase)); // R4
    AST_SINGLE_RETURNS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_gate && !alt_en && cnt == len && cnt != '0) |=> !phase); // R3
    AST_IN_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_gate |=> (!out_q && !phase && cnt == '0)); // R5
    AST_GATE_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_q |=> $stable(gate_q)); // R6
    AST_RESET_STATE: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_q && !phase)); // R8
endmodule

bind altdiv_clkgen altdiv_clkgen_chk #(.FW(altdiv_pkg::FIELD_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_gate(in_gate), .alt_en(alt_en),
    .phase(phase), .lvl_q(lvl_q), .gate_q(gate_q), .out_q(out_q),
    .cnt(cnt), .len(len)
);

// File: tb/tb_altdiv_clkgen.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random alternating configurations.
module tb_altdiv_clkgen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] cfg_a = '0, cfg_b = '0;
    logic clk_out;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    altdiv_clkgen dut (.clk_i(clk), .rst_ni(rst_n), .cfg_a_i(cfg_a),
                       .cfg_b_i(cfg_b), .clk_o(clk_out));

    // R1 encoding: fields stored minus one
    function automatic logic [31:0] mk_a(int ra, int rb, bit alt, bit og, bit ig);
        logic [31:0] w = '0;
        w[11:0] = 12'(ra - 1); w[23:12] = 12'(rb - 1);
        w[28] = alt; w[30] = og; w[31] = ig;
        return w;
    endfunction
    function automatic logic [31:0] mk_b(int ca, int cb, bit byp);
        logic [31:0] w = '0;
        w[11:0] = 12'(ca - 1); w[23:12] = 12'(cb - 1); w[24] = byp;
        return w;
    endfunction

    task automatic chk(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    // Check cycles lo..hi of a period of length len; en=0 expects low
    task automatic chk_cycles(int len, int lo, int hi, bit en, string req);
        for (int c = lo; c <= hi; c++) begin
            @(negedge clk);
            chk(clk_out, en && (c < len / 2), req);
        end
    endtask

    task automatic chk_low(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(clk_out, 1'b0, req);
        end
    endtask

    // Expected pattern from a fresh start in phase A
    task automatic run_seq(int ra, int rb, int ca, int cb, bit alt, int nper, string req);
        bit ph = 0;
        int rep = 0;
        for (int p = 0; p < nper; p++) begin
            int len = ph ? rb : ra;
            chk_cycles(len, 0, len - 1, 1'b1, req);
            if (alt) begin
                if (rep == (ph ? cb : ca) - 1) begin rep = 0; ph = ~ph; end
                else rep++;
            end
        end
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R8: reset state
        cfg_a = mk_a(4, 4, 1, 1, 1);
        chk_low(3, "R8 reset low");
        rst_n = 1'b1;
        cfg_a = mk_a(5, 13, 0, 1, 1); cfg_b = mk_b(3, 2, 0);
        run_seq(5, 13, 3, 2, 0, 4, "R2 single ratio 5");      // R1, R2
        cfg_a = mk_a(5, 13, 0, 1, 0);
        chk_low(3, "R5 in gate closed");
        // R9: ratio one
        cfg_a = mk_a(1, 9, 0, 1, 1);
        chk_low(8, "R9 ratio one low");
        cfg_a = mk_a(1, 9, 0, 1, 0);
        chk_low(2, "R5 in gate closed");
        cfg_a = mk_a(2, 9, 0, 1, 1);
        run_seq(2, 9, 1, 1, 0, 4, "R2 ratio two");
        cfg_a = mk_a(2, 9, 0, 1, 0);
        chk_low(2, "R5 in gate closed");
        // R3: random alternating configurations
        for (int it = 0; it < 8; it++) begin
            int ra = 1 + int'($urandom_range(23));
            int rb = 1 + int'($urandom_range(23));
            int ca = 1 + int'($urandom_range(3));
            int cb = 1 + int'($urandom_range(3));
            cfg_a = mk_a(ra, rb, 1, 1, 1); cfg_b = mk_b(ca, cb, 0);
            run_seq(ra, rb, ca, cb, 1, 2 * (ca + cb), "R3 alternating");
            cfg_a = mk_a(ra, rb, 1, 1, 0);
            chk_low(2, "R5 in gate closed");
        end
        // R5: close during phase B, reopen must start in phase A
        cfg_a = mk_a(3, 7, 1, 1, 1); cfg_b = mk_b(1, 2, 0);
        run_seq(3, 7, 1, 2, 1, 2, "R3 before close");
        cfg_a = mk_a(3, 7, 1, 1, 0);
        chk_low(3, "R5 in gate closed");
        cfg_a = mk_a(3, 7, 1, 1, 1);
        run_seq(3, 7, 1, 2, 1, 4, "R5 reopen in phase A");
        cfg_a = mk_a(3, 7, 1, 1, 0);
        chk_low(2, "R5 in gate closed");
        // R4: ratio rewrite in mid-period
        cfg_a = mk_a(6, 6, 0, 1, 1);
        chk_cycles(6, 0, 0, 1'b1, "R4 first cycle");
        cfg_a = mk_a(10, 6, 0, 1, 1);
        chk_cycles(6, 1, 5, 1'b1, "R4 old ratio kept");
        chk_cycles(10, 0, 9, 1'b1, "R4 new ratio");
        cfg_a = mk_a(10, 6, 0, 1, 0);
        chk_low(2, "R5 in gate closed");
        // R6: output gate opened and closed during a high pulse
        cfg_a = mk_a(8, 8, 0, 0, 1);
        chk_cycles(8, 0, 1, 1'b0, "R6 gate closed low");
        cfg_a = mk_a(8, 8, 0, 1, 1);
        chk_cycles(8, 2, 7, 1'b0, "R6 no partial pulse on open");
        chk_cycles(8, 0, 7, 1'b1, "R6 full period after open");
        chk_cycles(8, 0, 1, 1'b1, "R6 pulse start");
        cfg_a = mk_a(8, 8, 0, 0, 1);
        chk_cycles(8, 2, 7, 1'b1, "R6 pulse completes on close");
        chk_cycles(8, 0, 7, 1'b0, "R6 closed gate low");
        // R7: bypass ignores gates
        cfg_a = mk_a(8, 8, 0, 0, 0); cfg_b = mk_b(1, 1, 1);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 chk(clk_out, 1'b1, "R7 bypass high");
            @(negedge clk); #1 chk(clk_out, 1'b0, "R7 bypass low");
        end
        cfg_b = mk_b(2, 1, 0);
        // R8: reset during alternating run, restart in phase A
        cfg_a = mk_a(4, 9, 1, 1, 1);
        run_seq(4, 9, 2, 1, 1, 3, "R3 before reset");
        rst_n = 1'b0;
        chk_low(2, "R8 reset clears output");
        rst_n = 1'b1;
        run_seq(4, 9, 2, 1, 1, 6, "R8 restart in phase A");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule